// File: doc/BRIEF.md
# Serial DAC Input Frame Receiver

This block is the digital front end of a write-only serial DAC. It watches a three-wire serial port: an active-low frame select, a serial clock and a data line. All three are synchronised into a faster system clock. Each frame carries 24 bits, most significant bit first. The block samples a bit on each falling edge of the serial clock while the frame select is low. It keeps only the payload: the 2-bit operating mode and the 16-bit converter code.

When the 24th falling edge arrives, the block writes the code and the mode to its output registers in the same cycle and raises a one-cycle update strobe. If the frame select rises before that edge, the frame is discarded and the outputs keep their values. After a completed frame, further serial clocks are ignored until the frame select has gone high and then low again.

At reset the code register holds either zero or midscale, as a parameter selects. The mode is normal operation.

Top module: `dac_frame_rx`

## Requirements
- R1: While rst_ni is low and after it is released, update_o is 0 and mode_o is 00. code_o is 0x0000 when RESET_MIDSCALE is 0 and 0x8000 when it is 1, and it keeps that value until the first completed frame.
- R2: Bits are taken on falling edges of sclk_i, but only while sync_ni is low. The first bit received is bit 23 of the frame. Frame bits 23 down to 18 have no effect on any output.
- R3: On the 24th falling sclk_i edge of a frame, code_o takes frame bits 15..0 and mode_o takes frame bits 17..16, both in the same cycle.
- R4: mode_o encodes the operating mode as follows: 00 is normal, 01 is powered down with a 1 kΩ load, 10 is powered down with a 100 kΩ load, and 11 is powered down with the output floating. A power-down mode does not clear or alter the code delivered in the same frame.
- R5: If sync_ni rises before the 24th falling edge, code_o and mode_o stay unchanged and update_o stays low. The bits received so far are discarded.
- R6: After the 24th edge, further falling sclk_i edges are ignored for as long as sync_ni stays low.
- R7: A new frame begins only on a falling edge of sync_ni that follows a high level of sync_ni.
- R8: update_o is high for exactly one cycle for each completed frame. It is never raised for an aborted frame.
- R9: code_o and mode_o change only in a cycle in which update_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 16 | Converter code register |
| mode_o | output | 2 | Operating mode (R4 encoding) |
| update_o | output | 1 | One-cycle strobe on each completed frame |

## Verification
The checks rely on several assumptions about the inputs:
- Each level of sclk_i and sync_ni lasts longer than the synchroniser depth plus one system clock.
- sdi_i is stable while its falling sclk_i edge passes through the synchroniser.
- A falling edge of sync_ni never lands in the same system cycle as a falling sclk_i edge.

The stimulus keeps to these assumptions. Each serial clock phase lasts four system cycles, data changes only while sclk_i is low, and each edge of the frame select is separated from the nearest serial clock edge by at least four cycles.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_PD_1K   = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_PD_HIZ  = 2'b11
  } dac_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_DONE  = 2'b10
  } rx_state_e;

endpackage

// File: rtl/dfr_sync.sv
module dfr_sync #(
  parameter int unsigned        WIDTH   = 3,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= RST_VAL;
        else         pipe_q[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dfr_shifter.sv
module dfr_shifter
  import dfr_pkg::*;
#(
  parameter int unsigned FRAME_W   = 24,
  parameter int unsigned PAYLOAD_W = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_s_i,
  input  logic                 sync_ns_i,
  input  logic                 sdi_s_i,
  output logic                 commit_o,
  output logic [PAYLOAD_W-1:0] word_o,
  output logic                 sync_nq_o
);

  localparam int unsigned     CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

  rx_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [PAYLOAD_W-2:0]   shreg_q;
  logic                   sclk_q;
  logic                   sync_nq;
  logic                   sclk_fall;
  logic                   sync_fall;
  logic [PAYLOAD_W-1:0]   shift_nxt;

  always_comb begin
    sclk_fall = sclk_q & ~sclk_s_i;
    sync_fall = sync_nq & ~sync_ns_i;
    // pad bits fall off the top; only the payload window is stored
    shift_nxt = {shreg_q, sdi_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sync_nq <= 1'b1;
    end else begin
      sclk_q  <= sclk_s_i;
      sync_nq <= sync_ns_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sync_fall) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
            shreg_q <= '0;
          end
        end
        ST_SHIFT: begin
          if (sync_ns_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
          end else if (sclk_fall) begin
            shreg_q <= shift_nxt[PAYLOAD_W-2:0];
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_CNT) begin
              state_q  <= ST_DONE;
              commit_o <= 1'b1;
              word_o   <= shift_nxt;
            end
          end
        end
        ST_DONE: begin
          if (sync_ns_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sync_nq_o = sync_nq;

endmodule

// File: rtl/dfr_commit.sv
module dfr_commit
  import dfr_pkg::*;
#(
  parameter int unsigned CODE_W         = 16,
  parameter bit          RESET_MIDSCALE = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  logic [CODE_W+1:0]   word_i,
  output logic [CODE_W-1:0]   code_o,
  output dac_mode_e           mode_o,
  output logic                update_o
);

  logic [CODE_W-1:0] rst_code;

  generate
    if (RESET_MIDSCALE) begin : g_mid
      assign rst_code = {1'b1, {(CODE_W-1){1'b0}}};
    end else begin : g_zero
      assign rst_code = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o   <= rst_code;
      mode_o   <= MODE_RUN;
      update_o <= 1'b0;
    end else begin
      update_o <= commit_i;
      if (commit_i) begin
        code_o <= word_i[CODE_W-1:0];
        mode_o <= dac_mode_e'(word_i[CODE_W+1:CODE_W]);
      end
    end
  end

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dfr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned PAD_W          = 6,
  parameter int unsigned CODE_W         = 16,
  parameter bit          RESET_MIDSCALE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        mode_o,
  output logic              update_o
);

  localparam int unsigned MODE_W    = 2;
  localparam int unsigned PAYLOAD_W = CODE_W + MODE_W;
  localparam int unsigned FRAME_W   = PAD_W + PAYLOAD_W;

  logic [2:0]           pins_s;
  logic                 frame_commit;
  logic [PAYLOAD_W-1:0] frame_word;
  logic                 sync_prev;
  dac_mode_e            mode_q;

  dfr_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sync_ni, sclk_i, sdi_i}),
    .q_o    (pins_s)
  );

  dfr_shifter #(
    .FRAME_W   (FRAME_W),
    .PAYLOAD_W (PAYLOAD_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (pins_s[1]),
    .sync_ns_i (pins_s[2]),
    .sdi_s_i   (pins_s[0]),
    .commit_o  (frame_commit),
    .word_o    (frame_word),
    .sync_nq_o (sync_prev)
  );

  dfr_commit #(
    .CODE_W         (CODE_W),
    .RESET_MIDSCALE (RESET_MIDSCALE)
  ) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (frame_commit),
    .word_i   (frame_word),
    .code_o   (code_o),
    .mode_o   (mode_q),
    .update_o (update_o)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/dac_frame_rx_chk.sv
module dac_frame_rx_chk #(
  parameter int unsigned CODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic [1:0]        mode_i,
  input logic              update_i,
  input logic              commit_i,
  input logic              sync_prev_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_no_update_in_reset: assert (update_i == 1'b0);
    end
  end

  a_r3_commit_then_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> update_i);

  a_r5_commit_only_sync_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !sync_prev_i);

  a_r8_update_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> !update_i);

  a_r9_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_i) |-> update_i);

  a_r9_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_i) |-> update_i);

endmodule

bind dac_frame_rx dac_frame_rx_chk #(.CODE_W(CODE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .code_i      (code_o),
  .mode_i      (mode_o),
  .update_i    (update_o),
  .commit_i    (frame_commit),
  .sync_prev_i (sync_prev)
);

// File: tb/dac_frame_rx_tb_top.sv
`timescale 1ns/1ps
module dac_frame_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic [15:0] code, code_mid;
  logic [1:0]  mode, mode_mid;
  logic        upd, upd_mid;

  int checks = 0;
  int failures = 0;
  int upd_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_frame_rx #(.RESET_MIDSCALE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_o(code), .mode_o(mode), .update_o(upd));

  dac_frame_rx #(.RESET_MIDSCALE(1'b1)) dut_mid_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_o(code_mid), .mode_o(mode_mid), .update_o(upd_mid));

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  // {bits to send, frame}; 24 bits completes, fewer aborts
  localparam int NVEC = 8;
  localparam logic [28:0] VEC [NVEC] = '{
    {5'd24, 24'h00_1234},
    {5'd24, 24'hFC_ABCD},
    {5'd24, 24'h01_5555},
    {5'd10, 24'h02_0F0F},
    {5'd24, 24'h03_FFFF},
    {5'd23, 24'h00_0000},
    {5'd24, 24'h02_8001},
    {5'd1,  24'h3F_0000}
  };

  logic [15:0] exp_code = 16'h0000;
  logic [1:0]  exp_mode = 2'b00;
  int          exp_upd  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic d);
    sdi = d;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int n, input bit close);
    sync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) bit_out(w[23-i]);
    repeat (8) @(negedge clk);
    if (close) begin
      sync_n = 1'b1;
      repeat (12) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 update in reset", upd, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 zero reset code", code, 16'h0000);
    chk("R1 midscale reset code", code_mid, 16'h8000);
    chk("R1 reset mode", mode, 2'b00);
    chk("R1 no update after reset", upd_cnt, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] w;
      int n;
      w = VEC[v][23:0];
      n = int'(VEC[v][28:24]);
      send(w, n, 1'b1);
      if (n == 24) begin
        exp_code = w[15:0];
        exp_mode = w[17:16];
        exp_upd++;
        chk("R3 committed code", code, exp_code);
        chk("R4 committed mode", mode, exp_mode);
      end else begin
        chk("R5 aborted code kept", code, exp_code);
        chk("R5 aborted mode kept", mode, exp_mode);
      end
      chk("R8 update pulse count", upd_cnt, exp_upd);
    end

    // R2: pad bits all ones, MSB-first ordering of an asymmetric code
    send(24'hFE_C35A, 24, 1'b1);
    exp_upd++;
    chk("R2 pad ignored, msb first code", code, 16'hC35A);
    chk("R2 pad ignored mode", mode, 2'b10);

    // R4: floating-output power-down still carries its code
    send(24'h03_0001, 24, 1'b1);
    exp_upd++;
    chk("R4 power-down keeps code", code, 16'h0001);
    chk("R4 floating mode", mode, 2'b11);

    // R6: extra clocks after the 24th edge with sync held low
    send(24'h01_1111, 24, 1'b0);
    exp_upd++;
    chk("R6 frame before extra clocks", code, 16'h1111);
    for (int i = 0; i < 8; i++) bit_out(1'b0);
    repeat (8) @(negedge clk);
    chk("R6 extra clocks ignored code", code, 16'h1111);
    chk("R6 extra clocks ignored mode", mode, 2'b01);

    // R7: a full 24 clocks without a fresh sync fall
    for (int i = 0; i < 24; i++) bit_out(i[0]);
    repeat (8) @(negedge clk);
    chk("R7 no frame without sync fall", code, 16'h1111);
    chk("R8 no pulse without new frame", upd_cnt, exp_upd);
    sync_n = 1'b1;
    repeat (12) @(negedge clk);
    send(24'h00_3333, 24, 1'b1);
    exp_upd++;
    chk("R7 fresh frame commits", code, 16'h3333);
    chk("R7 fresh frame mode", mode, 2'b00);
    chk("R8 final pulse count", upd_cnt, exp_upd);
    chk("R3 midscale unit follows frame", code_mid, 16'h3333);

    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

endmodule